// File: doc/BRIEF.md
# Ring Oscillator Pair-Comparison Response Generator

This block turns the frequency differences of an array of free-running ring oscillators into a fixed-length response word. For each entry of a challenge list it picks two oscillators by index. It enables only those two for a measurement window of a programmable number of clock cycles. It counts rising edges of each one in the system clock domain, and records one bit that says whether the first oscillator ran faster than the second. One bit is produced per list entry, and the bits are packed into the response word in the order the entries are processed.

The oscillator outputs come in as primary inputs, and the per-oscillator gate enables go out as outputs. The oscillators themselves sit outside the block. Software or a controller places the challenge list on `challengeList`, sets `windowLen`, and pulses `start`. It keeps the list stable while `busy` is high, and reads `response` once `done` rises.

Top module: `ro_pair_puf`

## Requirements
- R1: A one-cycle `start` in the idle or finished state raises `busy` on the next clock edge and clears `done`. When the last comparison completes, `busy` falls and `done` rises in the same cycle. `done` then stays high until the next accepted `start`.
- R2: Entry i of `challengeList` occupies bits [i*20 +: 20]. The first index is in its low 10 bits and the second index is in its high 10 bits. Response bit i is 1 exactly when the edge count of the first-indexed oscillator is strictly greater than that of the second-indexed one.
- R3: When both counts are equal, and in particular when the two indices of an entry are the same, the response bit is 0.
- R4: Entries are processed in ascending order from 0 to NUM_BITS-1. The bit for entry i is stored at position i of `response`, with the LSB first.
- R5: Each comparison takes SETUP_CYC (4) setup cycles, then `windowLen` measurement cycles, then one decision cycle. `oscEn` has bits set only during the measurement cycles, and then exactly the bits of the current entry's two indices (one bit if they are equal).
- R6: A full run keeps `busy` high for exactly NUM_BITS*(SETUP_CYC+windowLen+1) cycles. `windowLen` is captured at `start`, and a value of 0 counts as 1.
- R7: `response` does not change while `done` is high.
- R8: Both 16-bit edge counters restart from zero for every comparison and saturate at their maximum value, so each bit depends only on its own entry.
- R9: A `start` pulse while `busy` is high is ignored: the run's length and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a response run |
| windowLen | input | 16 | Measurement window length in clock cycles |
| challengeList | input | 2560 | Packed list of NUM_BITS index pairs |
| oscIn | input | 1024 | Raw oscillator outputs |
| oscEn | output | 1024 | Per-oscillator gate enables |
| busy | output | 1 | Run in progress |
| done | output | 1 | Response valid and held |
| response | output | 128 | Assembled response word |

## Verification
The window for entry p opens SETUP_CYC cycles after its setup begins. The first setup cycle is the one right after the edge that accepted `start`. The bench therefore counts sampled cycles from that point and predicts the exact expected `oscEn` for every cycle. `done` is due after exactly NUM_BITS*(SETUP_CYC+windowLen+1) busy cycles, and the bench compares that count directly. Response bits are compared only once `done` is seen. The stimulus uses oscillator periods whose expected counts differ by at least four edges, or identical indices, so the expected bit does not depend on synchronizer phase.

// File: rtl/ro_puf_pkg.sv
package ro_puf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_MEASURE,
    ST_COMPARE,
    ST_DONE
  } puf_state_t;

  typedef struct packed {
    logic loadSel;
    logic clearCnt;
    logic countEn;
    logic capture;
  } puf_strobe_t;

endpackage

// File: rtl/ro_puf_edge_counter.sv
module ro_puf_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscRaw,
  input  logic             clear,
  input  logic             countEn,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic syncA, syncB, prevLvl;
  logic riseSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      prevLvl <= 1'b0;
    end else begin
      syncA   <= oscRaw;
      syncB   <= syncA;
      prevLvl <= syncB;
    end
  end

  assign riseSeen = syncB & ~prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (countEn && riseSeen && count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end

  // R8: a full counter never wraps
  assert_cnt_saturate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_MAX && !clear) |=> count == CNT_MAX);

  // R8: a clear always leaves the counter at zero
  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> count == '0);

endmodule

// File: rtl/ro_puf_ctrl.sv
module ro_puf_ctrl
  import ro_puf_pkg::*;
#(
  parameter int NUM_BITS  = 128,
  parameter int WIN_W     = 16,
  parameter int SETUP_CYC = 4,
  localparam int PIDX_W   = $clog2(NUM_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WIN_W-1:0]  windowLen,
  output puf_strobe_t       strb,
  output logic [PIDX_W-1:0] pairIdx,
  output logic              busy,
  output logic              done
);
  localparam logic [WIN_W-1:0]  SETUP_LAST = WIN_W'(SETUP_CYC - 1);
  localparam logic [PIDX_W-1:0] LAST_PAIR  = PIDX_W'(NUM_BITS - 1);

  puf_state_t       state;
  logic [WIN_W-1:0] cycCnt;
  logic [WIN_W-1:0] winLenQ;
  logic             idleLike;

  assign idleLike = (state == ST_IDLE) || (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cycCnt  <= '0;
      winLenQ <= WIN_W'(1);
      pairIdx <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state   <= ST_SETUP;
            cycCnt  <= '0;
            pairIdx <= '0;
            winLenQ <= (windowLen == '0) ? WIN_W'(1) : windowLen;
          end
        end
        ST_SETUP: begin
          if (cycCnt == SETUP_LAST) begin
            state  <= ST_MEASURE;
            cycCnt <= '0;
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        ST_MEASURE: begin
          if (cycCnt == winLenQ - 1'b1) begin
            state  <= ST_COMPARE;
            cycCnt <= '0;
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        ST_COMPARE: begin
          if (pairIdx == LAST_PAIR) begin
            state <= ST_DONE;
          end else begin
            pairIdx <= pairIdx + 1'b1;
            state   <= ST_SETUP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.loadSel  = (state == ST_SETUP) && (cycCnt == '0);
    strb.clearCnt = (state == ST_SETUP);
    strb.countEn  = (state == ST_MEASURE);
    strb.capture  = (state == ST_COMPARE);
  end

  assign busy = !idleLike;
  assign done = (state == ST_DONE);

  // R1: an accepted start launches a run on the next edge
  assert_start_launch_R1: assert property (@(posedge clk) disable iff (!rstN)
    (idleLike && start) |=> (busy && !done));

  // R9: start during a run does not end or restart it
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !(strb.capture && pairIdx == LAST_PAIR)) |=> (busy && pairIdx >= $past(pairIdx)));

  // R6: the window counter stays within the captured length
  assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.countEn |-> (cycCnt < winLenQ));

  // R4: entries advance one at a time in ascending order
  assert_pair_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && pairIdx != LAST_PAIR) |=> pairIdx == $past(pairIdx) + 1'b1);

endmodule

// File: rtl/ro_puf_datapath.sv
module ro_puf_datapath
  import ro_puf_pkg::*;
#(
  parameter int NUM_OSC  = 1024,
  parameter int NUM_BITS = 128,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = $clog2(NUM_OSC),
  localparam int ENT_W   = 2 * IDX_W,
  localparam int PIDX_W  = $clog2(NUM_BITS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  puf_strobe_t               strb,
  input  logic [PIDX_W-1:0]         pairIdx,
  input  logic [NUM_BITS*ENT_W-1:0] challengeList,
  input  logic [NUM_OSC-1:0]        oscIn,
  output logic [NUM_OSC-1:0]        oscEn,
  output logic [NUM_BITS-1:0]       response
);
  logic [IDX_W-1:0] selIdx [2];
  logic [CNT_W-1:0] chanCnt [2];
  logic             faster;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdx[0] <= '0;
      selIdx[1] <= '0;
    end else if (strb.loadSel) begin
      selIdx[0] <= challengeList[int'(pairIdx)*ENT_W +: IDX_W];
      selIdx[1] <= challengeList[int'(pairIdx)*ENT_W + IDX_W +: IDX_W];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_chan
    ro_puf_edge_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk     (clk),
      .rstN    (rstN),
      .oscRaw  (oscIn[selIdx[g]]),
      .clear   (strb.clearCnt),
      .countEn (strb.countEn),
      .count   (chanCnt[g])
    );
  end

  always_comb begin
    oscEn = '0;
    if (strb.countEn) begin
      oscEn[selIdx[0]] = 1'b1;
      oscEn[selIdx[1]] = 1'b1;
    end
  end

  assign faster = chanCnt[0] > chanCnt[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      response <= '0;
    end else if (strb.capture) begin
      response[pairIdx] <= faster;
    end
  end

  // R5: never more than the selected pair is gated on
  assert_osc_en_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(oscEn) <= 2);

  // R5: gates are closed outside the measurement window
  assert_osc_en_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (oscEn != '0) |-> strb.countEn);

  // R3: equal counts store a zero
  assert_tie_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && chanCnt[0] == chanCnt[1]) |=> !response[$past(pairIdx)]);

  // R2: a strictly larger first count stores a one
  assert_first_faster_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && chanCnt[0] > chanCnt[1]) |=> response[$past(pairIdx)]);

endmodule

// File: rtl/ro_pair_puf.sv
module ro_pair_puf
  import ro_puf_pkg::*;
#(
  parameter int NUM_OSC   = 1024,
  parameter int NUM_BITS  = 128,
  parameter int CNT_W     = 16,
  parameter int WIN_W     = 16,
  parameter int SETUP_CYC = 4,
  localparam int IDX_W    = $clog2(NUM_OSC),
  localparam int ENT_W    = 2 * IDX_W,
  localparam int PIDX_W   = $clog2(NUM_BITS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [WIN_W-1:0]          windowLen,
  input  logic [NUM_BITS*ENT_W-1:0] challengeList,
  input  logic [NUM_OSC-1:0]        oscIn,
  output logic [NUM_OSC-1:0]        oscEn,
  output logic                      busy,
  output logic                      done,
  output logic [NUM_BITS-1:0]       response
);
  puf_strobe_t       strb;
  logic [PIDX_W-1:0] pairIdx;

  ro_puf_ctrl #(
    .NUM_BITS  (NUM_BITS),
    .WIN_W     (WIN_W),
    .SETUP_CYC (SETUP_CYC)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .windowLen (windowLen),
    .strb      (strb),
    .pairIdx   (pairIdx),
    .busy      (busy),
    .done      (done)
  );

  ro_puf_datapath #(
    .NUM_OSC  (NUM_OSC),
    .NUM_BITS (NUM_BITS),
    .CNT_W    (CNT_W)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .pairIdx       (pairIdx),
    .challengeList (challengeList),
    .oscIn         (oscIn),
    .oscEn         (oscEn),
    .response      (response)
  );

  // R7: the finished response is held while done stays high
  assert_resp_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> $stable(response));

endmodule

// File: tb/test_ro_pair_puf.sv
`timescale 1ns/1ps
module test_ro_pair_puf;
  localparam int NUM_OSC   = 1024;
  localparam int NUM_BITS  = 128;
  localparam int IDX_W     = 10;
  localparam int ENT_W     = 20;
  localparam int SETUP_CYC = 4;
  localparam int FAST_IDX  = 0;
  localparam int SLOW_IDX  = 20;
  localparam int WD_LIMIT  = 150000;

  logic clk = 1'b0;
  logic rstN;
  logic start;
  logic [15:0] windowLen;
  logic [NUM_BITS*ENT_W-1:0] challengeList;
  logic [NUM_OSC-1:0] oscIn;
  logic [NUM_OSC-1:0] oscEn;
  logic busy, done;
  logic [NUM_BITS-1:0] response;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  int pairA [NUM_BITS];
  int pairB [NUM_BITS];
  bit expBit [NUM_BITS];
  int kind [NUM_BITS];

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  ro_pair_puf i_ro_pair_puf (
    .clk (clk), .rstN (rstN), .start (start), .windowLen (windowLen),
    .challengeList (challengeList), .oscIn (oscIn), .oscEn (oscEn),
    .busy (busy), .done (done), .response (response)
  );

  function automatic int halfNs(int k);
    return 11 + ((k * 13) % 29) * 2;
  endfunction

  // expected rising edges in the window, in hundredths
  function automatic int estHund(int k, int win);
    return (win * 1000) / (2 * halfNs(k));
  endfunction

  logic oscBit [NUM_OSC];
  for (genvar k = 0; k < NUM_OSC; k++) begin : g_osc
    localparam int H = 11 + ((k * 13) % 29) * 2;
    initial oscBit[k] = 1'b0;
    always begin
      if (oscEn[k] === 1'b1) begin
        #(H);
        oscBit[k] = ~oscBit[k];
      end else begin
        @(posedge oscEn[k]);
      end
    end
    assign oscIn[k] = oscBit[k];
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setPair(int i, int a, int b, int win, int kd);
    challengeList[i*ENT_W +: IDX_W] = IDX_W'(a);
    challengeList[i*ENT_W + IDX_W +: IDX_W] = IDX_W'(b);
    pairA[i] = a;
    pairB[i] = b;
    expBit[i] = (a != b) && (estHund(a, win) > estHund(b, win));
    kind[i] = kd;
  endtask

  task automatic randomPair(int i, int win);
    int a, b, d;
    a = $urandom % NUM_OSC;
    if ($urandom % 8 == 0) begin
      setPair(i, a, a, win, 0);
      return;
    end
    for (int g = 0; g < 1000; g++) begin
      b = $urandom % NUM_OSC;
      d = estHund(a, win) - estHund(b, win);
      if (d >= 400 || d <= -400) break;
    end
    setPair(i, a, b, win, 3);
  endtask

  task automatic runPuf(int win, bit poke, string tag);
    int t, per, p, ph, oscBad, effWin;
    logic [NUM_OSC-1:0] expEn;
    logic [NUM_BITS-1:0] held;
    effWin = (win == 0) ? 1 : win;
    per = SETUP_CYC + effWin + 1;
    windowLen = 16'(win);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && done === 1'b0, "R1", {tag, " busy after start"}, busy, 1);
    t = 0;
    oscBad = 0;
    while (done !== 1'b1 && cycles < WD_LIMIT) begin
      p = t / per;
      ph = t % per;
      expEn = '0;
      if (ph >= SETUP_CYC && ph < SETUP_CYC + effWin && p < NUM_BITS) begin
        expEn[pairA[p]] = 1'b1;
        expEn[pairB[p]] = 1'b1;
      end
      if (oscEn !== expEn || busy !== 1'b1) begin
        if (oscBad == 0)
          $display("FAIL R5 %s cycle %0d: oscEn ones %0d expected ones %0d",
                   tag, t, $countones(oscEn), $countones(expEn));
        oscBad++;
      end
      if (poke && t == 300) start = 1'b1;
      else start = 1'b0;
      t++;
      @(negedge clk);
    end
    start = 1'b0;
    checks++;
    if (oscBad != 0) fails++;
    check(t == NUM_BITS * per, "R6", {tag, " busy cycles"}, t, NUM_BITS * per);
    check(busy === 1'b0 && done === 1'b1, "R1", {tag, " done state"}, {busy, done}, 1);
    for (int i = 0; i < NUM_BITS; i++) begin
      case (kind[i])
        0: check(response[i] === 1'b0, "R3", {tag, " tie bit"}, response[i], 0);
        1: check(response[i] === expBit[i], "R4", {tag, " fast-first bit"}, response[i], expBit[i]);
        2: check(response[i] === expBit[i], "R8", {tag, " reversed bit after fast-first"}, response[i], expBit[i]);
        default: check(response[i] === expBit[i], poke ? "R9" : "R2", {tag, " bit"}, response[i], expBit[i]);
      endcase
    end
    held = response;
    for (int c = 0; c < 6; c++) @(negedge clk);
    check(response === held && done === 1'b1, "R7", {tag, " held response"}, response[63:0], held[63:0]);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0;
    start = 1'b0;
    windowLen = 16'd100;
    challengeList = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && response === '0 && oscEn === '0,
          "R1", "reset state", {busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: ties, fast-first, slow-first, random
    for (int i = 0; i < NUM_BITS; i++) begin
      case (i % 4)
        0: setPair(i, i * 7, i * 7, 100, 0);
        1: setPair(i, FAST_IDX, SLOW_IDX, 100, 1);
        2: setPair(i, SLOW_IDX, FAST_IDX, 100, 2);
        default: randomPair(i, 100);
      endcase
    end
    runPuf(100, 1'b0, "directed");

    for (int i = 0; i < NUM_BITS; i++) randomPair(i, 60);
    runPuf(60, 1'b1, "random-poke");

    for (int i = 0; i < NUM_BITS; i++) randomPair(i, 100);
    runPuf(100, 1'b0, "random");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles >= WD_LIMIT + 1000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule